// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst on a synchronous memory interface. When a burst begins, it captures an externally supplied start address. On each later clock where the active-low advance input is sampled low, it steps the two low-order address bits to the next position in the burst. The upper address bits pass through unchanged from the captured start address.

A static order-select input picks one of two step orders:

- **Interleaved order:** each generated offset is the start offset XORed with a running step count.
- **Linear order:** the offset counts upward from the start offset and wraps modulo four.

Burst starts may come from either of two start strobes, for example one from a host and one from a controller. A start strobe always wins over a simultaneous advance.

The block does not decode memory cycles, store data or handle chip enables. It only turns load and advance strobes into an address.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `wordAddr` is all zeros.
- R2: When `beginPrimary` or `beginSecondary` is sampled high on a rising edge, `wordAddr` equals the `startAddr` sampled on that edge from the next cycle on, and the burst restarts at its first position. This also applies in the middle of a burst.
- R3: When `advanceN` is sampled 0 and no start strobe is high, `wordAddr` moves to the next burst position after that edge. Bit 0 of the address toggles on every such step.
- R4: With `orderSel` = 0 (linear), the low two bits at burst position k (k = 0..3) equal (start offset + k) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With `orderSel` = 1 (interleaved), the low two bits at position k equal (start offset XOR k). For example, start 10 gives 10, 11, 00, 01.
- R6: When `advanceN` is sampled 1 and no start strobe is high, `wordAddr` holds its value.
- R7: Address bits above bit 1 stay equal to the captured start address for the whole burst.
- R8: An advance taken at the fourth position returns the address to the first position of the same sequence, and further advances repeat the sequence.
- R9: When a start strobe and `advanceN` = 0 are sampled on the same edge, the load takes effect and the advance is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| orderSel | input | 1 | Static order select: 1 = interleaved, 0 = linear |
| beginPrimary | input | 1 | Burst start strobe, active high |
| beginSecondary | input | 1 | Second burst start strobe, active high |
| advanceN | input | 1 | Advance strobe, active low |
| startAddr | input | ADDR_W | External start address captured on a burst start |
| wordAddr | output | ADDR_W | Current burst word address |

## Verification
The hardest case to reach from the ports is a burst that runs past its fourth position while suspend cycles sit between the steps. Only that case exposes a step count that wraps wrongly or a hold that leaks into the count.

The stimulus covers every start offset in both orders. Each burst takes six advances with hold cycles placed between them, so the wrap is crossed with idle cycles on either side. It also reloads in the middle of a burst through the second strobe, and drives a start strobe together with an advance on the same edge.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic load;     // capture a fresh start address, restart the step count
    logic advance;  // move to the next burst position
  } stepCmd_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic     beginPrimary,
  input  logic     beginSecondary,
  input  logic     advanceN,
  output stepCmd_t cmd
);

  logic anyBegin;

  assign anyBegin = beginPrimary | beginSecondary;

  // A start strobe masks a simultaneous advance (R9)
  always_comb begin
    cmd.load    = anyBegin;
    cmd.advance = ~advanceN & ~anyBegin;
  end

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCmd_t          cmd,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] wordAddr
);

  localparam int UPPER_W = ADDR_W - BURST_BITS;

  logic [ADDR_W-1:0]     baseAddr;
  logic [BURST_BITS-1:0] stepCnt;
  logic [BURST_BITS-1:0] baseLow;
  logic [BURST_BITS-1:0] interOffset;
  logic [BURST_BITS-1:0] linearOffset;
  logic [BURST_BITS-1:0] lowOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      stepCnt  <= '0;
    end else if (cmd.load) begin
      baseAddr <= startAddr;
      stepCnt  <= '0;
    end else if (cmd.advance) begin
      stepCnt  <= stepCnt + 1'b1;  // natural wrap after the last position (R8)
    end
  end

  assign baseLow = baseAddr[BURST_BITS-1:0];

  // Interleaved order: one XOR per offset bit
  for (genvar gi = 0; gi < BURST_BITS; gi++) begin : g_inter
    assign interOffset[gi] = baseLow[gi] ^ stepCnt[gi];
  end

  // Linear order: modulo add that wraps within the burst
  assign linearOffset = baseLow + stepCnt;

  assign lowOut   = orderSel ? interOffset : linearOffset;
  assign wordAddr = {baseAddr[ADDR_W-1:BURST_BITS], lowOut};

  // ---------------- assertions ----------------
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> wordAddr == $past(startAddr));

  p_step_toggles_lsb_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.advance |=> wordAddr[0] != $past(wordAddr[0]));

  p_linear_increment_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.advance && !orderSel) |=>
      wordAddr[BURST_BITS-1:0] == BURST_BITS'($past(wordAddr[BURST_BITS-1:0]) + 1'b1));

  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.advance) |=> $stable(wordAddr));

  p_upper_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> wordAddr[ADDR_W-1:BURST_BITS] == $past(wordAddr[ADDR_W-1:BURST_BITS]));

  initial begin
    assert (UPPER_W > 0) else $error("address must be wider than the burst offset");
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              orderSel,
  input  logic              beginPrimary,
  input  logic              beginSecondary,
  input  logic              advanceN,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] wordAddr
);

  stepCmd_t cmd;

  burst_ctrl ctrl_i (
    .beginPrimary   (beginPrimary),
    .beginSecondary (beginSecondary),
    .advanceN       (advanceN),
    .cmd            (cmd)
  );

  burst_datapath #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .orderSel  (orderSel),
    .startAddr (startAddr),
    .wordAddr  (wordAddr)
  );

  // A start strobe must always win over an advance (R9)
  p_load_priority_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((beginPrimary || beginSecondary) && !advanceN) |=> wordAddr == $past(startAddr));

endmodule

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;

  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              orderSel = 1'b1;
  logic              beginPrimary = 1'b0;
  logic              beginSecondary = 1'b0;
  logic              advanceN = 1'b1;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [ADDR_W-1:0] wordAddr;

  int nChecks = 0;
  int nFails  = 0;

  // reference state
  int refBase = 0;
  int refStep = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) dut_i (
    .clk            (clk),
    .rstN           (rstN),
    .orderSel       (orderSel),
    .beginPrimary   (beginPrimary),
    .beginSecondary (beginSecondary),
    .advanceN       (advanceN),
    .startAddr      (startAddr),
    .wordAddr       (wordAddr)
  );

  task automatic report(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareModel(input string tag);
    int pos;
    int expLow;
    int expUpper;
    pos      = refStep % 4;
    expLow   = orderSel ? ((refBase & 3) ^ pos) : (((refBase & 3) + pos) % 4);
    expUpper = refBase >> 2;
    report(tag, int'(wordAddr[1:0]), expLow);
    report("R7", int'(wordAddr[ADDR_W-1:2]), expUpper);
  endtask

  // One clock: drive after negedge, model at posedge, compare at next negedge
  task automatic runCycle(input logic p, input logic s, input logic advN, input string tag);
    string useTag;
    beginPrimary   = p;
    beginSecondary = s;
    advanceN       = advN;
    @(posedge clk);
    useTag = tag;
    if (p || s) begin
      refBase = int'(startAddr);
      refStep = 0;
    end else if (!advN) begin
      refStep++;
      if (refStep >= 4) useTag = "R8";
    end
    @(negedge clk);
    compareModel(useTag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    beginPrimary = 1'b0;
    beginSecondary = 1'b0;
    advanceN = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    report("R1", int'(wordAddr), 0);
    rstN = 1'b1;
    refBase = 0;
    refStep = 0;
    @(negedge clk);
    report("R1", int'(wordAddr), 0);
  endtask

  task automatic printSummary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    printSummary();
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int mode = 0; mode < 2; mode++) begin
      orderSel = mode[0];
      doReset();
      for (int st = 0; st < 4; st++) begin
        string ordTag;
        ordTag = mode == 1 ? "R3 R5" : "R3 R4";
        startAddr = ADDR_W'(16'hA5C0 + st * 16'h0104 + st);
        runCycle(st[0], ~st[0], 1'b1, "R2");
        // six advances with suspend cycles: crosses the wrap
        for (int k = 0; k < 6; k++) begin
          runCycle(1'b0, 1'b0, 1'b0, ordTag);
          if (k % 2 == 1) runCycle(1'b0, 1'b0, 1'b1, "R6");
          if (k == 2) runCycle(1'b0, 1'b0, 1'b1, "R6");
        end
        // reload in mid burst through the second strobe
        startAddr = ADDR_W'(16'h3C00 + (3 - st));
        runCycle(1'b0, 1'b1, 1'b1, "R2");
        runCycle(1'b0, 1'b0, 1'b0, ordTag);
        // load with advance on the same edge
        startAddr = ADDR_W'(16'h0F10 + st);
        runCycle(1'b1, 1'b0, 1'b0, "R9");
        runCycle(1'b0, 1'b0, 1'b1, "R6");
        runCycle(1'b0, 1'b0, 1'b0, ordTag);
      end
    end
    printSummary();
    $finish;
  end

endmodule